// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block hands transmit buffers from a host to a frame sink. The buffers are described by a ring of descriptors held in a small internal descriptor store. Each descriptor has three parts: a 16-bit control and status halfword, a 16-bit byte count and a 32-bit buffer pointer. The host fills descriptors through a write port and sets the ready bit of each one it wants sent. It programs the index of the first descriptor of the ring. It then writes a start command into the poll register.

Once started, the engine looks at the descriptor at its current index. If that descriptor is ready, the engine offers the pointer, the byte count and two per-buffer flags to the sink over a valid/ready handshake. It then waits for the sink's completion pulse. The completion carries a retry count and two error bits, and the engine writes these into the descriptor's status halfword while clearing its ready bit. It then moves to the next descriptor, or back to the ring start if the finished descriptor carried the wrap flag.

Only one descriptor is ever in flight. The engine stops, and drops its active flag, at the first descriptor that is not ready. The host can read every descriptor back through a read port to collect the written-back status.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset, pollActive is 0, frmValid is 0 and curIdx is 0.
- R2: Only a write to the poll register (regSel = 1) with bit 24 of regWdata set starts polling. Any other value leaves pollActive at 0, and no frame is offered even when descriptors are ready.
- R3: The engine offers only a descriptor whose status bit 15 (ready) is set. It drives frmAddr and frmLen from that descriptor's pointer and byte count, frmLast from status bit 11 and frmCrc from status bit 10.
- R4: frmValid stays high with frmAddr and frmLen unchanged until frmReady is seen. After acceptance, frmValid stays low until the completion pulse frmDone has arrived, so one descriptor at most is in flight.
- R5: On frmDone the descriptor's status halfword becomes {0, old bits 14:6, frmRetry[3:0], frmErr[1:0]}. Retry is at bits 5:2 and the errors at bits 1:0. The byte count and the pointer are left unchanged.
- R6: Descriptors are processed in ring order. After a descriptor whose status bit 13 (wrap) is clear, the index advances by one. After one whose wrap bit is set, the index returns to the ring start.
- R7: When the descriptor at curIdx has its ready bit clear, the engine sends nothing, clears pollActive and leaves curIdx on that descriptor. A later start command resumes there.
- R8: A ring start write (regSel = 0, index in the low bits of regWdata) made while pollActive is 0 also moves curIdx to that index. A write made while polling only changes where the next wrap lands.
- R9: A frmDone pulse while no descriptor is in flight is ignored: curIdx and all descriptor contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects ring start, 1 selects poll register |
| regWdata | input | 32 | Register write data |
| descWe | input | 1 | Descriptor write strobe |
| descIdx | input | IDXW | Descriptor index for writes |
| descWord | input | 1 | 0 writes {status, byte count}, 1 writes pointer |
| descWdata | input | 32 | Descriptor write data |
| rdIdx | input | IDXW | Descriptor index for reads |
| rdWord | input | 1 | 0 reads {status, byte count}, 1 reads pointer |
| rdData | output | 32 | Combinational descriptor read data |
| pollActive | output | 1 | Polling is running |
| curIdx | output | IDXW | Index of the descriptor the engine is on |
| frmValid | output | 1 | Buffer offered to the sink |
| frmReady | input | 1 | Sink accepts the offered buffer |
| frmAddr | output | 32 | Buffer pointer |
| frmLen | output | 16 | Buffer byte count |
| frmLast | output | 1 | Buffer ends a frame |
| frmCrc | output | 1 | Append CRC request |
| frmDone | input | 1 | Completion pulse from the sink |
| frmRetry | input | 4 | Retry count reported with frmDone |
| frmErr | input | 2 | Error bits reported with frmDone |

## Verification
The bench builds the engine with DEPTH = 8, a ring small enough that every index can be reached within a few buffers. With this size, random ring starts and wrap positions cover full rings, short sub-rings and a single-descriptor ring that wraps onto itself. Random ready patterns make the stop point land anywhere in the ring. Directed cases move the ring start both while idle and while polling, and pulse a completion with nothing in flight.

// File: rtl/tx_desc_ring_pkg.sv
package tx_desc_ring_pkg;
  localparam int READY_BIT = 15;
  localparam int WRAP_BIT  = 13;
  localparam int LAST_BIT  = 11;
  localparam int CRC_BIT   = 10;
  localparam int START_BIT = 24;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_WAIT
  } ringState_t;

  typedef struct packed {
    logic latchDesc;
    logic writeBack;
    logic advance;
    logic clrActive;
  } ringCtl_t;
endpackage

// File: rtl/tx_desc_ring_ctrl.sv
module tx_desc_ring_ctrl
  import tx_desc_ring_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pollActive,
  input  logic     descReady,
  input  logic     frmReady,
  input  logic     frmDone,
  output logic     frmValid,
  output ringCtl_t ctl
);
  ringState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE:  if (pollActive) nextState = ST_FETCH;
      ST_FETCH: begin
        if (descReady) begin
          ctl.latchDesc = 1'b1;
          nextState     = ST_SEND;
        end else begin
          ctl.clrActive = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_SEND:  if (frmReady) nextState = ST_WAIT;
      ST_WAIT: begin
        if (frmDone) begin
          ctl.writeBack = 1'b1;
          ctl.advance   = 1'b1;
          nextState     = ST_FETCH;
        end
      end
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign frmValid = (state == ST_SEND);
endmodule

// File: rtl/tx_desc_ring_dp.sv
module tx_desc_ring_dp
  import tx_desc_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  ringCtl_t        ctl,
  input  logic            regWe,
  input  logic            regSel,
  input  logic [31:0]     regWdata,
  input  logic            descWe,
  input  logic [IDXW-1:0] descIdx,
  input  logic            descWord,
  input  logic [31:0]     descWdata,
  input  logic [IDXW-1:0] rdIdx,
  input  logic            rdWord,
  output logic [31:0]     rdData,
  input  logic [3:0]      frmRetry,
  input  logic [1:0]      frmErr,
  output logic            pollActive,
  output logic [IDXW-1:0] curIdx,
  output logic            descReady,
  output logic [31:0]     frmAddr,
  output logic [15:0]     frmLen,
  output logic            frmLast,
  output logic            frmCrc
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

  logic [15:0] statMem [DEPTH];
  logic [15:0] lenMem  [DEPTH];
  logic [31:0] addrMem [DEPTH];
  logic [IDXW-1:0] ringBase;
  logic [15:0] curStat, wbStat;
  logic startWrite, baseWrite;
  logic [IDXW-1:0] seqIdx;

  assign curStat    = statMem[curIdx];
  assign descReady  = curStat[READY_BIT];
  assign wbStat     = {1'b0, curStat[14:6], frmRetry, frmErr};
  assign startWrite = regWe && regSel && regWdata[START_BIT];
  assign baseWrite  = regWe && !regSel;
  assign seqIdx     = (curIdx == LAST_IDX) ? '0 : curIdx + IDXW'(1);
  assign rdData     = rdWord ? addrMem[rdIdx] : {statMem[rdIdx], lenMem[rdIdx]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        statMem[i] <= '0;
        lenMem[i]  <= '0;
        addrMem[i] <= '0;
      end
    end else begin
      if (descWe) begin
        if (descWord) addrMem[descIdx] <= descWdata;
        else begin
          statMem[descIdx] <= descWdata[31:16];
          lenMem[descIdx]  <= descWdata[15:0];
        end
      end
      if (ctl.writeBack) statMem[curIdx] <= wbStat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollActive <= 1'b0;
      ringBase   <= '0;
      curIdx     <= '0;
    end else begin
      if (startWrite)         pollActive <= 1'b1;
      else if (ctl.clrActive) pollActive <= 1'b0;
      if (baseWrite) ringBase <= regWdata[IDXW-1:0];
      if (ctl.advance)
        curIdx <= curStat[WRAP_BIT] ? ringBase : seqIdx;
      else if (baseWrite && !pollActive)
        curIdx <= regWdata[IDXW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmAddr <= '0;
      frmLen  <= '0;
      frmLast <= 1'b0;
      frmCrc  <= 1'b0;
    end else if (ctl.latchDesc) begin
      frmAddr <= addrMem[curIdx];
      frmLen  <= lenMem[curIdx];
      frmLast <= curStat[LAST_BIT];
      frmCrc  <= curStat[CRC_BIT];
    end
  end
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import tx_desc_ring_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic            regSel,
  input  logic [31:0]     regWdata,
  input  logic            descWe,
  input  logic [IDXW-1:0] descIdx,
  input  logic            descWord,
  input  logic [31:0]     descWdata,
  input  logic [IDXW-1:0] rdIdx,
  input  logic            rdWord,
  output logic [31:0]     rdData,
  output logic            pollActive,
  output logic [IDXW-1:0] curIdx,
  output logic            frmValid,
  input  logic            frmReady,
  output logic [31:0]     frmAddr,
  output logic [15:0]     frmLen,
  output logic            frmLast,
  output logic            frmCrc,
  input  logic            frmDone,
  input  logic [3:0]      frmRetry,
  input  logic [1:0]      frmErr
);
  ringCtl_t ctl;
  logic descReady;

  tx_desc_ring_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .pollActive(pollActive), .descReady(descReady),
    .frmReady(frmReady), .frmDone(frmDone), .frmValid(frmValid), .ctl(ctl)
  );

  tx_desc_ring_dp #(.DEPTH(DEPTH), .IDXW(IDXW)) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .descWe(descWe), .descIdx(descIdx), .descWord(descWord), .descWdata(descWdata),
    .rdIdx(rdIdx), .rdWord(rdWord), .rdData(rdData),
    .frmRetry(frmRetry), .frmErr(frmErr),
    .pollActive(pollActive), .curIdx(curIdx), .descReady(descReady),
    .frmAddr(frmAddr), .frmLen(frmLen), .frmLast(frmLast), .frmCrc(frmCrc)
  );
endmodule

// File: rtl/tx_desc_ring_chk.sv
module tx_desc_ring_chk #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            pollActive,
  input logic            frmValid,
  input logic            frmReady,
  input logic [31:0]     frmAddr,
  input logic [15:0]     frmLen,
  input logic [IDXW-1:0] curIdx
);
  // R4
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && !frmReady |=> frmValid && $stable(frmAddr) && $stable(frmLen));

  // R4
  single_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && frmReady |=> !frmValid);

  // R2
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pollActive |=> !frmValid);

  // R7
  offer_needs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> pollActive);

  // R6
  idx_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> $stable(curIdx));
endmodule

bind tx_desc_ring tx_desc_ring_chk #(.IDXW(IDXW)) chkI (
  .clk(clk), .rstN(rstN), .pollActive(pollActive), .frmValid(frmValid),
  .frmReady(frmReady), .frmAddr(frmAddr), .frmLen(frmLen), .curIdx(curIdx)
);

// File: tb/tx_desc_ring_test.sv
module tx_desc_ring_test;
  localparam int DEPTH = 8;
  localparam int IDXW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regSel = 1'b0;
  logic [31:0] regWdata = '0;
  logic descWe = 1'b0, descWord = 1'b0;
  logic [IDXW-1:0] descIdx = '0, rdIdx = '0;
  logic [31:0] descWdata = '0;
  logic rdWord = 1'b0;
  logic [31:0] rdData;
  logic pollActive, frmValid, frmLast, frmCrc;
  logic [IDXW-1:0] curIdx;
  logic frmReady = 1'b0, frmDone = 1'b0;
  logic [31:0] frmAddr;
  logic [15:0] frmLen;
  logic [3:0] frmRetry = '0;
  logic [1:0] frmErr = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [15:0] mStat [DEPTH];
  logic [15:0] mLen  [DEPTH];
  logic [31:0] mAddr [DEPTH];
  logic [IDXW-1:0] mBase = '0, mIdx = '0;
  bit mActive = 0;

  always #5 clk = ~clk;

  tx_desc_ring #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .descWe(descWe), .descIdx(descIdx), .descWord(descWord), .descWdata(descWdata),
    .rdIdx(rdIdx), .rdWord(rdWord), .rdData(rdData),
    .pollActive(pollActive), .curIdx(curIdx),
    .frmValid(frmValid), .frmReady(frmReady), .frmAddr(frmAddr), .frmLen(frmLen),
    .frmLast(frmLast), .frmCrc(frmCrc),
    .frmDone(frmDone), .frmRetry(frmRetry), .frmErr(frmErr)
  );

  function automatic logic [15:0] wbStat(logic [15:0] s, logic [3:0] rt, logic [1:0] er);
    return {1'b0, s[14:6], rt, er};
  endfunction

  function automatic logic [IDXW-1:0] nextIdx(logic [IDXW-1:0] i, logic [15:0] s);
    if (s[13]) return mBase;
    return (i == IDXW'(DEPTH - 1)) ? '0 : i + IDXW'(1);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostReg(bit sel, logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
    if (sel) begin
      if (data[24]) mActive = 1;
    end else begin
      mBase = data[IDXW-1:0];
      if (!mActive) mIdx = data[IDXW-1:0];
    end
  endtask

  task automatic hostDesc(int idx, logic [15:0] s, logic [15:0] len, logic [31:0] addr);
    @(negedge clk);
    descWe = 1'b1; descIdx = IDXW'(idx); descWord = 1'b0; descWdata = {s, len};
    @(negedge clk);
    descWord = 1'b1; descWdata = addr;
    @(negedge clk);
    descWe = 1'b0;
    mStat[idx] = s; mLen[idx] = len; mAddr[idx] = addr;
  endtask

  task automatic verifyAll(string req);
    for (int i = 0; i < DEPTH; i++) begin
      rdIdx = IDXW'(i); rdWord = 1'b0; #1;
      check(rdData == {mStat[i], mLen[i]}, req, rdData, {mStat[i], mLen[i]});
      rdWord = 1'b1; #1;
      check(rdData == mAddr[i], req, rdData, mAddr[i]);
    end
  endtask

  task automatic runRing();
    for (int guard = 0; guard < 2000; guard++) begin
      @(negedge clk);
      if (frmValid) begin
        logic [15:0] s;
        logic [31:0] a0;
        logic [15:0] l0;
        logic [3:0] rt;
        logic [1:0] er;
        s = mStat[mIdx];
        check(s[15] && curIdx == mIdx, "R3 offered descriptor ready", {s, 13'b0, curIdx}, {s, 13'b0, mIdx});
        check(frmAddr == mAddr[mIdx] && frmLen == mLen[mIdx], "R3 addr/len",
              {frmAddr, frmLen}, {mAddr[mIdx], mLen[mIdx]});
        check(frmLast == s[11] && frmCrc == s[10], "R3 last/crc flags",
              {frmLast, frmCrc}, {s[11], s[10]});
        a0 = frmAddr; l0 = frmLen;
        for (int h = 0; h < int'($urandom % 3); h++) begin
          @(negedge clk);
          check(frmValid && frmAddr == a0 && frmLen == l0, "R4 hold offer", {frmValid, frmAddr}, {1'b1, a0});
        end
        frmReady = 1'b1;
        @(negedge clk);
        frmReady = 1'b0;
        check(!frmValid, "R4 single in flight", frmValid, 0);
        for (int d = 0; d < int'($urandom % 4); d++) begin
          @(negedge clk);
          check(!frmValid, "R4 wait for done", frmValid, 0);
        end
        rt = 4'($urandom); er = 2'($urandom);
        frmRetry = rt; frmErr = er; frmDone = 1'b1;
        @(negedge clk);
        frmDone = 1'b0;
        mStat[mIdx] = wbStat(s, rt, er);
        mIdx = nextIdx(mIdx, s);
      end else if (!pollActive) begin
        check(!mStat[mIdx][15], "R7 stop on not-ready", mStat[mIdx], 0);
        check(curIdx == mIdx, "R6 R7 stop index", curIdx, mIdx);
        mActive = 0;
        break;
      end
    end
    check(!mActive, "R7 ring stopped", mActive, 0);
  endtask

  task automatic fillRing(int wrapAt, logic [7:0] readyMask);
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] s;
      s = 16'($urandom);
      s[15] = readyMask[i];
      s[13] = (i == wrapAt);
      hostDesc(i, s, 16'($urandom), $urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!pollActive && !frmValid && curIdx == 0, "R1 reset state", {pollActive, frmValid, curIdx}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!pollActive && !frmValid && curIdx == 0, "R1 after reset release", {pollActive, frmValid, curIdx}, 0);

    // R2: ready ring, wrong poll value
    fillRing(7, 8'b0001_1111);
    hostReg(1'b1, 32'hFEFF_FFFF);
    repeat (10) begin
      @(negedge clk);
      check(!frmValid && !pollActive, "R2 no start without bit 24", {frmValid, pollActive}, 0);
    end
    hostReg(1'b1, 32'h0100_0000);
    runRing();
    check(curIdx == 5, "R7 stopped at index 5", curIdx, 5);
    verifyAll("R5 write-back");

    // R9: completion with nothing in flight
    frmRetry = 4'hF; frmErr = 2'h3;
    @(negedge clk); frmDone = 1'b1;
    @(negedge clk); frmDone = 1'b0;
    @(negedge clk);
    check(curIdx == mIdx && !pollActive, "R9 stray done idx", curIdx, mIdx);
    verifyAll("R9 stray done contents");

    // R8: base write while idle moves index
    hostReg(1'b0, 32'd3);
    check(curIdx == 3, "R8 idle base write", curIdx, 3);
    fillRing(7, 8'b1111_1000);
    hostReg(1'b1, 32'h0100_0000);
    hostReg(1'b0, 32'd5);
    check(curIdx == 3, "R8 base write while active keeps index", curIdx, 3);
    runRing();
    check(curIdx == 5, "R6 R8 wrap to new base", curIdx, 5);
    verifyAll("R5 after wrap");

    // R7: resume from stop point
    hostDesc(5, 16'h8000, 16'd64, 32'h1000_0040);
    hostReg(1'b1, 32'h0100_0000);
    runRing();
    check(curIdx == 6, "R7 resume continues", curIdx, 6);

    // R6: single descriptor ring wrapping to itself
    hostReg(1'b0, 32'd6);
    fillRing(6, 8'b0100_0000);
    hostReg(1'b1, 32'h0100_0000);
    runRing();
    check(curIdx == 6, "R6 single-entry ring", curIdx, 6);
    verifyAll("R5 single-entry");

    // random rings
    for (int r = 0; r < 12; r++) begin
      int base, wrapAt;
      base = int'($urandom % DEPTH);
      wrapAt = base + int'($urandom % (DEPTH - base));
      hostReg(1'b0, 32'(base));
      check(curIdx == IDXW'(base), "R8 random idle base", curIdx, base);
      fillRing(wrapAt, 8'($urandom));
      hostReg(1'b1, 32'h0100_0000 | ($urandom & 32'hFEFF_FFFF));
      runRing();
      verifyAll("R5 R6 random ring");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule